// File: doc/BRIEF.md
# Wake-up and Standby Status Register

This block is a single 32-bit APB status register for a power controller. It holds four fields. A software-controlled enable chooses whether the external wake pin can wake the device. A read-only copy of the supply voltage detector's comparator output is shown only while the detector is enabled. Two sticky flags record that a wake-up event happened and that the device has been in standby.

The wake pin goes through a synchronizer and a rising-edge detector, and that detector is gated by the enable. An RTC alarm pulse also sets the wake-up flag. A standby indication sets the standby flag. Each flag has a one-cycle clear strobe that comes from a neighbouring control register.

There are two reset domains. The power-on reset clears everything. The system reset clears the enable and the detector copy but leaves both sticky flags in place. The flags therefore survive system reset and standby exit, and software can find out why the device restarted. A read of the register takes one extra bus cycle.

Top module: `pwr_wake_status`

## Requirements
- R1: After power-on reset (`por_ni` low) the register at offset 0x04 reads 0x00000000.
- R2: Bits 31:9 and 7:3 always read 0. Only offset 0x04 is decoded: a read of any other offset returns 0, and a write to any other offset changes nothing.
- R3: Bit 8 is the wake-pin enable. It reads back the last value written and drives `wake_en_o`. Both the system reset `rst_ni` and the power-on reset clear it.
- R4: While bit 8 is 1, a rising edge of `wake_pin_i` sets bit 0 (the wake-up flag). The pin passes two synchronizer flops first, and a rising edge means the previous synchronized sample was 0 and the current one is 1. While bit 8 is 0, pin activity never sets bit 0. A pin that is already high when bit 8 is set produces no event.
- R5: A one-cycle `rtc_alarm_i` pulse sets bit 0 in the following cycle.
- R6: Bit 0 is cleared only by power-on reset or by a `clr_wake_i` strobe. System reset and standby exit leave it unchanged.
- R7: A `standby_i` pulse sets bit 1 (the standby flag). Only power-on reset or a `clr_stby_i` strobe clears it. System reset leaves it unchanged.
- R8: If a set event and the clear strobe for the same flag arrive in the same cycle, the flag ends up set.
- R9: Bit 2 is `vdet_cmp_i` registered for one cycle while `vdet_en_i` is 1. It reads 0 while `vdet_en_i` is 0 and after any reset.
- R10: A write to the register changes only bit 8. Values written to bits 0, 1, 2 and to the reserved bits are ignored.
- R11: A read holds `pready_o` low for exactly the first cycle of the access phase. A write completes in its first access cycle.
- R12: `pslverr_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready |
| pslverr_o | output | 1 | APB error, tied low |
| wake_pin_i | input | 1 | Asynchronous wake pin |
| rtc_alarm_i | input | 1 | RTC alarm pulse |
| vdet_cmp_i | input | 1 | Voltage detector comparator, 1 = supply below threshold |
| vdet_en_i | input | 1 | Voltage detector enable |
| standby_i | input | 1 | Pulse that marks a standby episode |
| clr_wake_i | input | 1 | Clear strobe for the wake-up flag |
| clr_stby_i | input | 1 | Clear strobe for the standby flag |
| wake_en_o | output | 1 | Current wake-pin enable, for pad configuration |

## Verification
The bench applies a system reset with both flags set. A design that wired the flags to the system reset would lose them, and one that left the enable on the power-on reset alone would keep bit 8. The bench raises the pin while the enable is 0 and then sets the enable with the pin still high. A detector that looked at the level, or that gated the event after the edge register, would raise a false wake-up. The bench also fires a set and its clear strobe in the same cycle, where clear priority would lose the event. It writes all ones to the register, which a design with writable flag bits or reserved bits would reflect back. It counts the `pready_o` low cycles on reads and writes, so a missing or doubled wait state is reported.

// File: rtl/pwr_stat_pkg.sv
package pwr_stat_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned STAT_OFFSET = 32'h04;
  localparam int unsigned WUF_BIT     = 0;
  localparam int unsigned SBF_BIT     = 1;
  localparam int unsigned VDET_BIT    = 2;
  localparam int unsigned WEN_BIT     = 8;

  typedef struct packed {
    logic wake_en;
    logic vdet;
    logic stby;
    logic wuf;
  } stat_fields_t;

  function automatic logic [DATA_W-1:0] pack_stat(input stat_fields_t f);
    logic [DATA_W-1:0] w;
    w           = '0;
    w[WUF_BIT]  = f.wuf;
    w[SBF_BIT]  = f.stby;
    w[VDET_BIT] = f.vdet;
    w[WEN_BIT]  = f.wake_en;
    return w;
  endfunction
endpackage

// File: rtl/pwr_pin_edge.sv
module pwr_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  output logic rise_o
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], pin_i};
  end

  // sh_q[SYNC_STAGES-1] is the current synchronized sample, the next bit the previous one
  assign rise_o = en_i & sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/pwr_sticky_flag.sv
module pwr_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/pwr_apb_slot.sv
module pwr_apb_slot #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned OFFSET  = 4,
  parameter int unsigned RD_WAIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output logic              hit_o,
  output logic              wr_o,
  output logic              pready_o,
  output logic              pslverr_o
);
  localparam int unsigned CNT_W = (RD_WAIT < 1) ? 1 : $clog2(RD_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RD_WAIT);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(OFFSET);

  logic             access;
  logic             rd_acc;
  logic [CNT_W-1:0] cnt_q;

  assign access = psel_i & penable_i;
  assign rd_acc = access & ~pwrite_i;
  assign hit_o  = (paddr_i == MY_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (rd_acc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    else                               cnt_q <= '0;
  end

  assign pready_o  = ~rd_acc | (cnt_q == CNT_MAX);
  assign wr_o      = access & pwrite_i & hit_o;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/pwr_wake_status.sv
module pwr_wake_status
  import pwr_stat_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RD_WAIT     = 1
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              wake_pin_i,
  input  logic              rtc_alarm_i,
  input  logic              vdet_cmp_i,
  input  logic              vdet_en_i,
  input  logic              standby_i,
  input  logic              clr_wake_i,
  input  logic              clr_stby_i,
  output logic              wake_en_o
);
  logic         sys_rst_n;
  logic         hit, wr;
  logic         pin_rise;
  logic         wake_en_q, vdet_q, wuf_q, stby_q;
  stat_fields_t fields;
  logic         unused_wdata;

  assign sys_rst_n    = por_ni & rst_ni;
  assign unused_wdata = ^{pwdata_i[DATA_W-1:WEN_BIT+1], pwdata_i[WEN_BIT-1:0]};

  pwr_apb_slot #(
    .ADDR_W (ADDR_W),
    .OFFSET (STAT_OFFSET),
    .RD_WAIT(RD_WAIT)
  ) u_apb (
    .clk_i    (clk_i),
    .rst_ni   (sys_rst_n),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .hit_o    (hit),
    .wr_o     (wr),
    .pready_o (pready_o),
    .pslverr_o(pslverr_o)
  );

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) wake_en_q <= 1'b0;
    else if (wr)    wake_en_q <= pwdata_i[WEN_BIT];
  end

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) vdet_q <= 1'b0;
    else            vdet_q <= vdet_en_i & vdet_cmp_i;
  end

  pwr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(sys_rst_n),
    .pin_i (wake_pin_i),
    .en_i  (wake_en_q),
    .rise_o(pin_rise)
  );

  // flags live in the power-on domain only
  pwr_sticky_flag u_wuf (
    .clk_i (clk_i),
    .rst_ni(por_ni),
    .set_i (pin_rise | rtc_alarm_i),
    .clr_i (clr_wake_i),
    .flag_o(wuf_q)
  );

  pwr_sticky_flag u_sbf (
    .clk_i (clk_i),
    .rst_ni(por_ni),
    .set_i (standby_i),
    .clr_i (clr_stby_i),
    .flag_o(stby_q)
  );

  assign fields    = '{wake_en: wake_en_q, vdet: vdet_q, stby: stby_q, wuf: wuf_q};
  assign prdata_o  = (psel_i && !pwrite_i && hit) ? pack_stat(fields) : '0;
  assign wake_en_o = wake_en_q;
endmodule

// File: rtl/pwr_wake_status_chk.sv
module pwr_wake_status_chk (
  input logic        clk_i,
  input logic        por_ni,
  input logic        rst_ni,
  input logic        psel_i,
  input logic        penable_i,
  input logic        pwrite_i,
  input logic [31:0] prdata_o,
  input logic        pready_o,
  input logic        pslverr_o,
  input logic        rtc_alarm_i,
  input logic        vdet_en_i,
  input logic        standby_i,
  input logic        clr_wake_i,
  input logic        clr_stby_i,
  input logic        wuf_q,
  input logic        stby_q,
  input logic        vdet_q
);
  logic setup_rd_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) setup_rd_q <= 1'b0;
    else         setup_rd_q <= psel_i & ~penable_i & ~pwrite_i;
  end

  p_no_err_r12: assert property (@(posedge clk_i) disable iff (!por_ni) !pslverr_o);

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!por_ni)
    (prdata_o & 32'hFFFF_FEF8) == 32'h0);

  p_rd_wait_r11: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (setup_rd_q && psel_i && penable_i) |-> !pready_o);

  p_alarm_sets_r5: assert property (@(posedge clk_i) disable iff (!por_ni)
    rtc_alarm_i |=> wuf_q);

  p_wuf_sticky_r6: assert property (@(posedge clk_i) disable iff (!por_ni)
    (wuf_q && !clr_wake_i) |=> wuf_q);

  p_stby_set_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
    standby_i |=> stby_q);

  p_stby_sticky_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
    (stby_q && !clr_stby_i) |=> stby_q);

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
    (rtc_alarm_i && clr_wake_i) |=> wuf_q);

  p_vdet_off_r9: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    !vdet_en_i |=> !vdet_q);
endmodule

bind pwr_wake_status pwr_wake_status_chk u_chk (
  .clk_i      (clk_i),
  .por_ni     (por_ni),
  .rst_ni     (rst_ni),
  .psel_i     (psel_i),
  .penable_i  (penable_i),
  .pwrite_i   (pwrite_i),
  .prdata_o   (prdata_o),
  .pready_o   (pready_o),
  .pslverr_o  (pslverr_o),
  .rtc_alarm_i(rtc_alarm_i),
  .vdet_en_i  (vdet_en_i),
  .standby_i  (standby_i),
  .clr_wake_i (clr_wake_i),
  .clr_stby_i (clr_stby_i),
  .wuf_q      (wuf_q),
  .stby_q     (stby_q),
  .vdet_q     (vdet_q)
);

// File: tb/tb_pwr_wake_status.sv
module tb_pwr_wake_status;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        por_ni = 1'b0, rst_ni = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [7:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        pready_o, pslverr_o;
  logic        wake_pin_i = 1'b0, rtc_alarm_i = 1'b0, vdet_cmp_i = 1'b0, vdet_en_i = 1'b0;
  logic        standby_i = 1'b0, clr_wake_i = 1'b0, clr_stby_i = 1'b0;
  logic        wake_en_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwr_wake_status dut (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d, output int waits);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b0; paddr_i = a; penable_i = 1'b0;
    @(negedge clk_i);
    penable_i = 1'b1; #1;
    waits = 0;
    while (!pready_o && waits < 8) begin
      waits++;
      @(negedge clk_i); #1;
    end
    d = prdata_o;
    check({31'b0, pslverr_o}, 32'h0, "R12 pslverr");
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0;
  endtask

  function automatic logic [31:0] rd_val(input logic [7:0] a);
    return 32'h0;
  endfunction

  task automatic rd(output logic [31:0] d);
    int w;
    apb_rd(8'h04, d, w);
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, output int waits);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b1; paddr_i = a; pwdata_i = d; penable_i = 1'b0;
    @(negedge clk_i);
    penable_i = 1'b1; #1;
    waits = pready_o ? 0 : 1;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    int w;
    apb_wr(8'h04, d, w);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk_i); s = 1'b1;
    @(negedge clk_i); s = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk_i); por_ni = 1'b0; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    por_ni = 1'b1; rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_por();
    rd(d);
    check(d, 32'h0, "R1 reset value");
    check({31'b0, wake_en_o}, 32'h0, "R3 wake_en_o after reset");
  endtask

  task automatic t_bus_timing();
    logic [31:0] d; int w;
    apb_rd(8'h04, d, w);
    check(w, 1, "R11 read wait states");
    apb_wr(8'h04, 32'h0, w);
    check(w, 0, "R11 write wait states");
  endtask

  task automatic t_enable_rw();
    logic [31:0] d; int w;
    wr(32'h100);
    rd(d);
    check(d, 32'h100, "R3 enable readback");
    check({31'b0, wake_en_o}, 32'h1, "R3 wake_en_o");
    apb_wr(8'h08, 32'h0, w);
    rd(d);
    check(d, 32'h100, "R2 write to other offset ignored");
    apb_rd(8'h08, d, w);
    check(d, 32'h0, "R2 other offset reads zero");
    wr(32'h0);
    rd(d);
    check(d, 32'h0, "R3 enable cleared by write");
  endtask

  task automatic t_pin_disabled();
    logic [31:0] d;
    do_por();
    @(negedge clk_i); wake_pin_i = 1'b1;
    repeat (5) @(negedge clk_i);
    wake_pin_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rd(d);
    check(d, 32'h0, "R4 edge with enable 0 ignored");
    @(negedge clk_i); wake_pin_i = 1'b1;
    repeat (5) @(negedge clk_i);
    wr(32'h100);
    repeat (5) @(negedge clk_i);
    rd(d);
    check(d, 32'h100, "R4 pin high before enable gives no event");
    wake_pin_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_pin_enabled();
    logic [31:0] d;
    do_por();
    wr(32'h100);
    @(negedge clk_i); wake_pin_i = 1'b1;
    repeat (5) @(negedge clk_i);
    rd(d);
    check(d, 32'h101, "R4 qualified edge sets wake flag");
    wake_pin_i = 1'b0;
    pulse(clr_wake_i);
    rd(d);
    check(d, 32'h100, "R6 clear strobe clears wake flag");
  endtask

  task automatic t_alarm_and_clear();
    logic [31:0] d;
    do_por();
    pulse(rtc_alarm_i);
    rd(d);
    check(d, 32'h1, "R5 alarm sets wake flag");
    @(negedge clk_i); rtc_alarm_i = 1'b1; clr_wake_i = 1'b1;
    @(negedge clk_i); rtc_alarm_i = 1'b0; clr_wake_i = 1'b0;
    rd(d);
    check(d, 32'h1, "R8 set beats clear on wake flag");
    pulse(clr_wake_i);
    @(negedge clk_i); standby_i = 1'b1; clr_stby_i = 1'b1;
    @(negedge clk_i); standby_i = 1'b0; clr_stby_i = 1'b0;
    rd(d);
    check(d, 32'h2, "R8 set beats clear on standby flag");
  endtask

  task automatic t_standby_and_sysreset();
    logic [31:0] d;
    do_por();
    wr(32'h100);
    pulse(standby_i);
    pulse(rtc_alarm_i);
    rd(d);
    check(d, 32'h103, "R7 standby flag set");
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i); rst_ni = 1'b1;
    rd(d);
    check(d, 32'h3, "R6 R7 flags survive system reset, R3 enable cleared");
    pulse(clr_stby_i);
    rd(d);
    check(d, 32'h1, "R7 clear strobe clears standby flag");
    do_por();
    rd(d);
    check(d, 32'h0, "R1 power-on reset clears flags");
  endtask

  task automatic t_ro_writes();
    logic [31:0] d;
    do_por();
    pulse(rtc_alarm_i);
    wr(32'hFFFF_FFFF);
    rd(d);
    check(d, 32'h101, "R10 R2 write all ones");
    wr(32'h0000_0000);
    rd(d);
    check(d, 32'h1, "R10 write zero keeps wake flag");
  endtask

  task automatic t_vdet();
    logic [31:0] d;
    do_por();
    @(negedge clk_i); vdet_cmp_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rd(d);
    check(d, 32'h0, "R9 detector disabled reads zero");
    vdet_en_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rd(d);
    check(d, 32'h4, "R9 below threshold");
    vdet_cmp_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rd(d);
    check(d, 32'h0, "R9 above threshold");
    vdet_cmp_i = 1'b1;
    @(negedge clk_i); rst_ni = 1'b0; vdet_en_i = 1'b0;
    repeat (2) @(negedge clk_i); rst_ni = 1'b1;
    rd(d);
    check(d, 32'h0, "R9 zero after reset until enabled");
    vdet_cmp_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_bus_timing();
    t_enable_rw();
    t_pin_disabled();
    t_pin_enabled();
    t_alarm_and_clear();
    t_standby_and_sysreset();
    t_ro_writes();
    t_vdet();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule